// File: doc/BRIEF.md
# I2C Register-File Target

This block is a target on a two-wire serial bus that exposes an 8-bit register file through an 8-bit internal pointer. A fast system clock oversamples the clock and data lines. Each line passes through a two-flop synchronizer. Edge logic then finds the clock edges and the START, repeated START and STOP conditions. A strap pin chooses one of two device addresses.

A write carries a pointer byte and then any number of data bytes. Each data byte goes to the next address in turn. A read returns bytes from the current pointer, and the pointer advances after each byte. A random read is a pointer write followed by a repeated START and a read. The pointer keeps its value between transactions, so a later read with no pointer phase picks up where the last transfer left off.

The block drives SDA only as an open-drain pull-down enable. It reaches the register file through a combinational read port and a one-cycle write strobe.

Top module: `i2c_reg_target`

## Requirements
- R1: The 7-bit device address is 0x1C (first byte 0x38 write / 0x39 read) when `addrStrap` is 0, and 0x1D (0x3A / 0x3B) when it is 1. The first byte carries the address MSB first, then the R/W bit, where 1 means read. A matching first byte is acknowledged by pulling SDA low during the 9th clock. A non-matching one is not acknowledged, and the transaction that follows causes no write.
- R2: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. A START in any phase, including a repeated START in the middle of a write, restarts the address phase.
- R3: In a write, the byte after the address byte loads the pointer. Each later byte is written to the pointer address, and the pointer then increments by one. Every byte is acknowledged.
- R4: A data byte aimed at an address at or above `NUM_REGS` raises no `regWrEn`. It is still acknowledged and still advances the pointer, and registers in range keep their contents.
- R5: A random read (pointer write, repeated START, read address) returns the register at the written pointer first.
- R6: In a read, the master's ACK after a byte requests the byte at the next address. After a NACK, the block leaves SDA released until the next START.
- R7: A read with no pointer phase starts at the pointer left by the previous transaction.
- R8: The SDA pull-down changes only while SCL is low.
- R9: After reset, SDA is released, `regWrEn` is low and the pointer (`regRdAddr`) is 0.
- R10: The pointer is 8 bits wide and wraps from 0xFF to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rstN | input | 1 | Active-low synchronous reset |
| scl | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| addrStrap | input | 1 | Selects which of the two device addresses is used |
| sdaDriveLow | output | 1 | 1 pulls SDA low (open-drain enable) |
| regRdAddr | output | 8 | Current pointer, used as the read address |
| regRdData | input | 8 | Register contents at `regRdAddr` (combinational) |
| regWrEn | output | 1 | One-cycle write strobe |
| regWrAddr | output | 8 | Write address, valid with `regWrEn` |
| regWrData | output | 8 | Write data, valid with `regWrEn` |

## Verification
Two events can land on the same SCL falling edge. The write strobe for the 8th bit of a data byte is issued there, and so is the pointer increment that the next byte or a following read depends on. The bench provokes this with a write burst that crosses `NUM_REGS` and one that crosses 0xFF. It then judges the result by reading back through random reads and a current-address read. These must show both the in-range writes and the advanced pointer, while the out-of-range addresses see no strobe at all.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  // Bus-level observations produced by the datapath
  typedef struct packed {
    logic sclLvl;
    logic sdaLvl;
    logic sclRise;
    logic sclFall;
    logic startEv;
    logic stopEv;
  } busEvt_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic loadSub;
    logic writeByte;
    logic loadTx;
    logic shiftTx;
    logic ackOn;
    logic sdaOff;
  } dpCmd_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RD_ACK
  } tgtState_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rstN) pipe <= '1;   // idle bus reads high
    else       pipe <= {pipe[STAGES-2:0], din};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2c_tgt_dp.sv
module i2c_tgt_dp
  import i2c_tgt_pkg::*;
#(
  parameter int NUM_REGS    = 32,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          scl,
  input  logic          sdaIn,
  input  dpCmd_t        cmd,
  input  logic [7:0]    regRdData,
  output busEvt_t       evt,
  output logic [7:0]    rxByte,
  output logic          sdaDriveLow,
  output logic [AW-1:0] regRdAddr,
  output logic          regWrEn,
  output logic [AW-1:0] regWrAddr,
  output logic [7:0]    regWrData
);
  logic sclS, sdaS, sclD, sdaD;
  logic [6:0] txRest;
  logic [AW-1:0] ptr;
  logic ptrInRange;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sclSync (.clk(clk), .rstN(rstN), .din(scl),   .q(sclS));
  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sdaSync (.clk(clk), .rstN(rstN), .din(sdaIn), .q(sdaS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  always_comb begin
    evt.sclLvl  = sclS;
    evt.sdaLvl  = sdaS;
    evt.sclRise = sclS & ~sclD;
    evt.sclFall = ~sclS & sclD;
    evt.startEv = sclS & sclD & sdaD & ~sdaS;
    evt.stopEv  = sclS & sclD & ~sdaD & sdaS;
  end

  assign ptrInRange = (32'(ptr) < NUM_REGS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte      <= '0;
      txRest      <= '0;
      ptr         <= '0;
      sdaDriveLow <= 1'b0;
      regWrEn     <= 1'b0;
      regWrAddr   <= '0;
      regWrData   <= '0;
    end else begin
      regWrEn <= 1'b0;
      if (cmd.shiftIn) rxByte <= {rxByte[6:0], sdaS};
      if (cmd.loadSub) ptr <= AW'(rxByte);
      if (cmd.writeByte) begin
        regWrEn   <= ptrInRange;
        regWrAddr <= ptr;
        regWrData <= rxByte;
        ptr       <= ptr + 1'b1;
      end
      if (cmd.loadTx) begin
        txRest      <= regRdData[6:0];
        sdaDriveLow <= ~regRdData[7];
        ptr         <= ptr + 1'b1;
      end
      if (cmd.shiftTx) begin
        sdaDriveLow <= ~txRest[6];
        txRest      <= {txRest[5:0], 1'b0};
      end
      if (cmd.ackOn)  sdaDriveLow <= 1'b1;
      if (cmd.sdaOff) sdaDriveLow <= 1'b0;
    end
  end

  assign regRdAddr = ptr;
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR0 = 7'h1C,
  parameter logic [6:0] DEV_ADDR1 = 7'h1D
) (
  input  logic       clk,
  input  logic       rstN,
  input  busEvt_t    evt,
  input  logic [7:0] rxByte,
  input  logic       addrStrap,
  output dpCmd_t     cmd
);
  tgtState_t state, stNext;
  logic [3:0] bitCnt, cntNext;
  logic rdMode, rdNext, mAck, mAckNext;
  logic [6:0] devAddr;

  assign devAddr = addrStrap ? DEV_ADDR1 : DEV_ADDR0;

  always_comb begin
    cmd      = '0;
    stNext   = state;
    cntNext  = bitCnt;
    rdNext   = rdMode;
    mAckNext = mAck;
    if (evt.startEv) begin
      stNext     = ST_ADDR;
      cntNext    = '0;
      cmd.sdaOff = 1'b1;
    end else if (evt.stopEv) begin
      stNext     = ST_IDLE;
      cntNext    = '0;
      cmd.sdaOff = 1'b1;
    end else begin
      case (state)
        ST_ADDR, ST_SUB, ST_WDATA: begin
          if (evt.sclRise && bitCnt != 4'd8) begin
            cmd.shiftIn = 1'b1;
            cntNext     = bitCnt + 4'd1;
          end else if (evt.sclFall && bitCnt == 4'd8) begin
            cntNext = '0;
            if (state == ST_ADDR) begin
              if (rxByte[7:1] == devAddr) begin
                cmd.ackOn = 1'b1;
                rdNext    = rxByte[0];
                stNext    = ST_ADDR_ACK;
              end else begin
                stNext = ST_IDLE;
              end
            end else if (state == ST_SUB) begin
              cmd.loadSub = 1'b1;
              cmd.ackOn   = 1'b1;
              stNext      = ST_SUB_ACK;
            end else begin
              cmd.writeByte = 1'b1;
              cmd.ackOn     = 1'b1;
              stNext        = ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (evt.sclFall) begin
            if (rdMode) begin
              cmd.loadTx = 1'b1;
              stNext     = ST_RDATA;
            end else begin
              cmd.sdaOff = 1'b1;
              stNext     = ST_SUB;
            end
          end
        end
        ST_SUB_ACK, ST_WDATA_ACK: begin
          if (evt.sclFall) begin
            cmd.sdaOff = 1'b1;
            stNext     = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (evt.sclFall) begin
            if (bitCnt == 4'd7) begin
              cmd.sdaOff = 1'b1;
              cntNext    = '0;
              stNext     = ST_RD_ACK;
            end else begin
              cmd.shiftTx = 1'b1;
              cntNext     = bitCnt + 4'd1;
            end
          end
        end
        ST_RD_ACK: begin
          if (evt.sclRise) mAckNext = ~evt.sdaLvl;
          if (evt.sclFall) begin
            if (mAck) begin
              cmd.loadTx = 1'b1;
              stNext     = ST_RDATA;
            end else begin
              stNext = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      rdMode <= 1'b0;
      mAck   <= 1'b0;
    end else begin
      state  <= stNext;
      bitCnt <= cntNext;
      rdMode <= rdNext;
      mAck   <= mAckNext;
    end
  end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter int         NUM_REGS    = 32,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR0   = 7'h1C,
  parameter logic [6:0] DEV_ADDR1   = 7'h1D
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sdaIn,
  input  logic       addrStrap,
  output logic       sdaDriveLow,
  output logic [7:0] regRdAddr,
  input  logic [7:0] regRdData,
  output logic       regWrEn,
  output logic [7:0] regWrAddr,
  output logic [7:0] regWrData
);
  busEvt_t    busEvt;
  dpCmd_t     dpCmd;
  logic [7:0] rxByte;

  i2c_tgt_ctrl #(.DEV_ADDR0(DEV_ADDR0), .DEV_ADDR1(DEV_ADDR1)) u_ctrl (
    .clk(clk), .rstN(rstN), .evt(busEvt), .rxByte(rxByte),
    .addrStrap(addrStrap), .cmd(dpCmd)
  );

  i2c_tgt_dp #(.NUM_REGS(NUM_REGS), .SYNC_STAGES(SYNC_STAGES), .AW(8)) u_dp (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaIn), .cmd(dpCmd),
    .regRdData(regRdData), .evt(busEvt), .rxByte(rxByte),
    .sdaDriveLow(sdaDriveLow), .regRdAddr(regRdAddr), .regWrEn(regWrEn),
    .regWrAddr(regWrAddr), .regWrData(regWrData)
  );
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk
  import i2c_tgt_pkg::*;
#(
  parameter int NUM_REGS = 32
) (
  input logic       clk,
  input logic       rstN,
  input busEvt_t    busEvt,
  input logic       sdaDriveLow,
  input logic [7:0] regRdAddr,
  input logic       regWrEn,
  input logic [7:0] regWrAddr
);
  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (32'(regWrAddr) < NUM_REGS)); // R4

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (regRdAddr == 8'(regWrAddr + 8'd1))); // R3

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn); // R3

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !$past(busEvt.sclLvl)); // R8

  AST_START_FREES_SDA: assert property (@(posedge clk) disable iff (!rstN)
    busEvt.startEv |=> !sdaDriveLow); // R2
endmodule

bind i2c_reg_target i2c_tgt_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rstN(rstN), .busEvt(busEvt), .sdaDriveLow(sdaDriveLow),
  .regRdAddr(regRdAddr), .regWrEn(regWrEn), .regWrAddr(regWrAddr)
);

// File: tb/tb_i2c_reg_target.sv
module tb_i2c_reg_target;
  localparam int NUM  = 32;
  localparam int Q    = 10;
  localparam logic [7:0] OOR_VAL = 8'hEE;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic mSda = 1'b1;
  logic strapPin = 1'b0;
  logic sdaDriveLow, regWrEn;
  logic [7:0] regRdAddr, regRdData, regWrAddr, regWrData;
  wire sdaBus = mSda & ~sdaDriveLow;

  int total = 0;
  int bad = 0;
  int oorWrites = 0;
  int sdaViol = 0;
  logic [7:0] regs  [256];
  logic [7:0] model [256];

  always #2.5 clk = ~clk;

  i2c_reg_target dut (
    .clk(clk), .rstN(rstN), .scl(sclM), .sdaIn(sdaBus), .addrStrap(strapPin),
    .sdaDriveLow(sdaDriveLow), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData)
  );

  initial for (int i = 0; i < 256; i++) begin regs[i] = 8'h00; model[i] = 8'h00; end

  assign regRdData = (32'(regRdAddr) < NUM) ? regs[regRdAddr] : OOR_VAL;

  logic prevDrive = 1'b0, prevScl = 1'b1;
  always @(posedge clk) begin
    if (regWrEn) begin
      if (32'(regWrAddr) < NUM) regs[regWrAddr] <= regWrData;
      else oorWrites++;
    end
    if (rstN && sdaDriveLow != prevDrive && sclM && prevScl) sdaViol++;
    prevDrive <= sdaDriveLow;
    prevScl   <= sclM;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expVal(input logic [7:0] a);
    return (32'(a) < NUM) ? model[a] : OOR_VAL;
  endfunction

  task automatic waitQ(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(1);
    mSda = 1'b0; waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic busStop();
    mSda = 1'b0; waitQ(1);
    sclM = 1'b1; waitQ(1);
    mSda = 1'b1; waitQ(1);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitQ(1);
      sclM = 1'b1; waitQ(2);
      sclM = 1'b0;
    end
    waitQ(1);
    mSda = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(1);
    ack = ~sdaBus; waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic readByte(input bit giveAck, output logic [7:0] b);
    mSda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      waitQ(1);
      sclM = 1'b1; waitQ(1);
      b = {b[6:0], sdaBus}; waitQ(1);
      sclM = 1'b0;
    end
    waitQ(1);
    mSda = giveAck ? 1'b0 : 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(2);
    sclM = 1'b0;
    mSda = 1'b1; waitQ(1);
  endtask

  task automatic writeSeq(input logic [7:0] dev8, input logic [7:0] sub, input logic [7:0] seed, input int len);
    logic ack;
    busStart();
    sendByte(dev8, ack);  chk(ack === 1'b1, "R1 address ack", ack, 1);
    sendByte(sub, ack);   chk(ack === 1'b1, "R3 pointer ack", ack, 1);
    for (int i = 0; i < len; i++) begin
      logic [7:0] a;
      a = 8'(sub + i);
      sendByte(8'(seed + i), ack);
      chk(ack === 1'b1, "R3 data ack", ack, 1);
      if (32'(a) < NUM) model[a] = 8'(seed + i);
    end
    busStop();
  endtask

  task automatic readRandom(input logic [7:0] dev8, input logic [7:0] sub, input int len, input string tag);
    logic ack;
    logic [7:0] d;
    busStart();
    sendByte(dev8, ack);          chk(ack === 1'b1, "R5 address ack", ack, 1);
    sendByte(sub, ack);           chk(ack === 1'b1, "R5 pointer ack", ack, 1);
    busStart();
    sendByte(dev8 | 8'h01, ack);  chk(ack === 1'b1, "R2 repeated start ack", ack, 1);
    for (int i = 0; i < len; i++) begin
      readByte(i != len - 1, d);
      chk(d === expVal(8'(sub + i)), tag, d, expVal(8'(sub + i)));
    end
    chk(sdaDriveLow === 1'b0, "R6 released after NACK", sdaDriveLow, 0);
    busStop();
  endtask

  // {pointer, seed, length}
  localparam logic [19:0] VEC [5] = '{
    {8'h00, 8'h11, 4'd3},
    {8'h05, 8'hA0, 4'd1},
    {8'h1E, 8'h50, 4'd4},
    {8'h10, 8'hF0, 4'd2},
    {8'h02, 8'h7C, 4'd2}
  };

  initial begin
    logic ack;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    // R9 reset state
    chk(sdaDriveLow === 1'b0, "R9 sda released in reset", sdaDriveLow, 0);
    chk(regWrEn === 1'b0, "R9 no write in reset", regWrEn, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(regRdAddr === 8'h00, "R9 pointer zero", regRdAddr, 0);
    chk(sdaDriveLow === 1'b0, "R9 sda released after reset", sdaDriveLow, 0);
    waitQ(2);

    // table: write burst then random readback (R3, R4, R5, R6)
    for (int v = 0; v < 5; v++) begin
      writeSeq(8'h38, VEC[v][19:12], VEC[v][11:4], int'(VEC[v][3:0]));
      readRandom(8'h38, VEC[v][19:12], int'(VEC[v][3:0]), "R3 R5 readback");
    end
    // R4: burst over 0x1E..0x21 must not strobe out-of-range addresses
    chk(oorWrites == 0, "R4 no out-of-range strobe", oorWrites, 0);

    // R7: last readback left pointer at 0x04; read two bytes with no pointer phase
    busStart();
    sendByte(8'h39, ack);  chk(ack === 1'b1, "R7 read address ack", ack, 1);
    readByte(1'b1, d);     chk(d === expVal(8'h04), "R7 current read byte0", d, expVal(8'h04));
    readByte(1'b0, d);     chk(d === expVal(8'h05), "R7 current read byte1", d, expVal(8'h05));
    busStop();
    chk(regRdAddr === 8'h06, "R6 pointer after ACKed sequence", regRdAddr, 8'h06);

    // R1: strap selects address
    busStart();
    sendByte(8'h3A, ack);  chk(ack === 1'b0, "R1 wrong address no ack", ack, 0);
    sendByte(8'h08, ack);
    sendByte(8'h66, ack);
    busStop();
    readRandom(8'h38, 8'h08, 1, "R1 ignored transaction left data");
    strapPin = 1'b1;
    waitQ(1);
    busStart();
    sendByte(8'h38, ack);  chk(ack === 1'b0, "R1 strap1 rejects 0x38", ack, 0);
    busStop();
    writeSeq(8'h3A, 8'h08, 8'h99, 1);
    readRandom(8'h3A, 8'h08, 1, "R1 strap1 access");
    strapPin = 1'b0;
    waitQ(1);

    // R10 + R4: 0xFF is out of range, next byte wraps to 0x00
    writeSeq(8'h38, 8'hFF, 8'h01, 2);
    readRandom(8'h38, 8'h00, 1, "R10 wrap to zero");
    chk(oorWrites == 0, "R4 wrap write not strobed", oorWrites, 0);

    // R2: repeated START in the middle of a write restarts address phase
    busStart();
    sendByte(8'h38, ack);
    sendByte(8'h0C, ack);
    sendByte(8'h33, ack);
    busStart();
    sendByte(8'h39, ack);  chk(ack === 1'b1, "R2 restart mid write", ack, 1);
    model[8'h0C] = 8'h33;
    readByte(1'b0, d);     chk(d === expVal(8'h0D), "R2 read after restart", d, expVal(8'h0D));
    busStop();
    readRandom(8'h38, 8'h0C, 1, "R2 byte before restart kept");

    // R8 observed at the pins over the whole run
    chk(sdaViol == 0, "R8 sda changes only with scl low", sdaViol, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule